// File: doc/BRIEF.md
# Stop-Mode Wake-Up Controller

This block manages a small core's low-power stop state. A stop request from the core turns off both oscillators and drops the core-run output. The request is honoured only if the watchdog control register has been written since reset or since the previous stop entry. Otherwise the block leaves the core running, pulses an internal reset and puts the clock mode back to its default.

While stopped, the block watches a fixed set of interrupt sources: four external pins, two externally clocked serial events, two externally clocked timer events and a key-on input. A source is armed when the core enters stop only if three things hold at that moment: the source's enable bit is 1, its request flag is 0, and the global interrupt-disable flag is 0. The two timers that provide the stabilization delay can never be armed.

An armed event restarts every oscillator that the held clock mode had running. It pulses a timer-chain overwrite indication and then holds the core for a stabilization count. When the count ends, the core runs again and the request bits of the sources that woke it are set. An asynchronous reset aborts stop or stabilization at any point.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, core_run_o is 1, xin_on_o is 1, xcin_on_o is 0 and sub_sel_o is 0 (the default clock mode). All pulse outputs are 0, and the watchdog-written flag is clear.
- R2: A stop_req_i in run, with the watchdog-written flag set, stops the core: from the next cycle core_run_o, xin_on_o and xcin_on_o are 0. The stop entry clears the watchdog-written flag.
- R3: A stop_req_i in run with no watchdog write since reset or the last stop entry leaves the core running. In that case int_rst_o pulses for one cycle and the clock mode returns to the default.
- R4: A wdt_wr_i in the same cycle as stop_req_i counts as a prior watchdog write, so stop is entered.
- R5: Source bits are: 0 to 3 the external pins, 4 and 5 the serial events, 6 and 7 the timer X/Y events, 8 key-on, and 9 and 10 the stabilization timers. A bit is armed only if its irq_en_i bit is 1, its irq_flag_i bit is 0 and iflag_i is 0 in the stop-entry cycle. Bits 9 and 10 are never armed. Unarmed events leave the block stopped.
- R6: An armed irq_ev_i bit while stopped brings xin_on_o and xcin_on_o back to the held clock mode from the next cycle. tmr_ovr_o pulses in that same cycle.
- R7: With sub_sel_o 0, core_run_o rises exactly 2^CNT_W cycles (8192 by default) after the cycle in which the oscillators are restored.
- R8: With sub_sel_o 1, core_run_o rises one cycle after the oscillators are restored.
- R9: irq_set_o pulses for one cycle together with the rise of core_run_o. It carries every armed source that fired while stopped or stabilizing.
- R10: The clock mode is written by cm_wr_i only while the core runs. The mode is held unchanged through stop and stabilization.
- R11: Asserting rst_n low during stabilization aborts it. The block comes back in the R1 state, with the watchdog-written flag clear.
- R12: stop_req_i during stabilization is ignored, and the count length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock, one tick per main-oscillator cycle |
| rst_n | input | 1 | Asynchronous active-low reset (reset wake) |
| stop_req_i | input | 1 | Core executes a stop request |
| wdt_wr_i | input | 1 | Core writes the watchdog control register |
| cm_wr_i | input | 1 | Clock-mode register write strobe |
| cm_xin_i | input | 1 | Written main-oscillator enable |
| cm_xcin_i | input | 1 | Written sub-oscillator enable |
| cm_sub_sel_i | input | 1 | Written system clock select, 1 = sub |
| iflag_i | input | 1 | Global interrupt-disable flag |
| irq_en_i | input | NSRC | Per-source interrupt enable bits |
| irq_flag_i | input | NSRC | Per-source interrupt request flags |
| irq_ev_i | input | NSRC | Per-source raw wake events |
| core_run_o | output | 1 | Core clock released |
| xin_on_o | output | 1 | Main oscillator enable |
| xcin_on_o | output | 1 | Sub oscillator enable |
| sub_sel_o | output | 1 | System clock select, 1 = sub |
| tmr_ovr_o | output | 1 | Timer-chain registers overwritten for stabilization |
| irq_set_o | output | NSRC | One-cycle pulse setting waking request bits |
| int_rst_o | output | 1 | Internal reset from an unguarded stop request |

## Verification
Two events can fall in the same cycle: the watchdog write and the stop request. The bench drives both in one cycle and expects stop entry with no internal reset. It then stops again without a write and expects the internal reset, which shows the flag was consumed. A second overlap is an armed event arriving during stabilization at the moment the counter runs. This is judged by the stabilization length staying at 8192 and by irq_set_o carrying both sources.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int SRC_N = 11;
    localparam logic [SRC_N-1:0] SRC_WAKE_OK = 11'b001_1111_1111;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2
    } swc_state_e;

    typedef struct packed {
        logic xin;
        logic xcin;
        logic sub_sel;
    } clk_mode_t;

    localparam clk_mode_t MODE_DEFAULT = '{xin: 1'b1, xcin: 1'b0, sub_sel: 1'b0};
endpackage

// File: rtl/swc_wake_qual.sv
module swc_wake_qual #(
    parameter int NSRC = swc_pkg::SRC_N,
    parameter logic [NSRC-1:0] WAKE_OK = swc_pkg::SRC_WAKE_OK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] flag_i,
    input  logic            iflag_i,
    input  logic [NSRC-1:0] ev_i,
    output logic [NSRC-1:0] hit_o
);
    typedef struct packed {
        logic [NSRC-1:0] armed;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        if (capture_i) begin
            qual_d.armed = en_i & ~flag_i & WAKE_OK & {NSRC{~iflag_i}};
        end
    end

    assign hit_o = ev_i & qual_q.armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= qual_d;
    end
endmodule

// File: rtl/swc_stab_cnt.sv
module swc_stab_cnt #(
    parameter int CNT_W = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic load_full_i,
    input  logic dec_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.cnt = load_full_i ? CNT_FULL : '0;
        end else if (dec_i && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    assign zero_o = (cnt_q.cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/swc_clk_mode.sv
module swc_clk_mode
    import swc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  clk_mode_t wr_val_i,
    input  logic      restore_i,
    output clk_mode_t mode_o
);
    typedef struct packed {
        clk_mode_t mode;
    } mode_reg_t;

    mode_reg_t mreg_d, mreg_q;

    always_comb begin
        mreg_d = mreg_q;
        if (restore_i)  mreg_d.mode = MODE_DEFAULT;
        else if (wr_i)  mreg_d.mode = wr_val_i;
    end

    assign mode_o = mreg_q.mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mreg_q.mode <= MODE_DEFAULT;
        else        mreg_q      <= mreg_d;
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int NSRC  = swc_pkg::SRC_N,
    parameter int CNT_W = 13,
    parameter logic [NSRC-1:0] WAKE_OK = swc_pkg::SRC_WAKE_OK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_req_i,
    input  logic            wdt_wr_i,
    input  logic            cm_wr_i,
    input  logic            cm_xin_i,
    input  logic            cm_xcin_i,
    input  logic            cm_sub_sel_i,
    input  logic            iflag_i,
    input  logic [NSRC-1:0] irq_en_i,
    input  logic [NSRC-1:0] irq_flag_i,
    input  logic [NSRC-1:0] irq_ev_i,
    output logic            core_run_o,
    output logic            xin_on_o,
    output logic            xcin_on_o,
    output logic            sub_sel_o,
    output logic            tmr_ovr_o,
    output logic [NSRC-1:0] irq_set_o,
    output logic            int_rst_o
);
    typedef struct packed {
        swc_state_e      state;
        logic            wdt_seen;
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] irq_set;
        logic            tmr_ovr;
        logic            int_rst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            capture;
    logic            cnt_load;
    logic            cnt_dec;
    logic            cnt_zero;
    logic            restore;
    logic            mode_wr;
    logic [NSRC-1:0] hit;
    clk_mode_t       mode;
    clk_mode_t       mode_wr_val;

    swc_wake_qual #(.NSRC(NSRC), .WAKE_OK(WAKE_OK)) i_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .en_i      (irq_en_i),
        .flag_i    (irq_flag_i),
        .iflag_i   (iflag_i),
        .ev_i      (irq_ev_i),
        .hit_o     (hit)
    );

    swc_stab_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cnt_load),
        .load_full_i (~mode.sub_sel),
        .dec_i       (cnt_dec),
        .zero_o      (cnt_zero)
    );

    assign mode_wr_val = '{xin: cm_xin_i, xcin: cm_xcin_i, sub_sel: cm_sub_sel_i};
    assign mode_wr     = cm_wr_i && (ctl_q.state == ST_RUN);

    swc_clk_mode i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (mode_wr),
        .wr_val_i  (mode_wr_val),
        .restore_i (restore),
        .mode_o    (mode)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.irq_set = '0;
        ctl_d.tmr_ovr = 1'b0;
        ctl_d.int_rst = 1'b0;
        capture       = 1'b0;
        cnt_load      = 1'b0;
        cnt_dec       = 1'b0;
        restore       = 1'b0;
        if (wdt_wr_i) ctl_d.wdt_seen = 1'b1;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (stop_req_i) begin
                    if (ctl_q.wdt_seen || wdt_wr_i) begin
                        ctl_d.state    = ST_STOP;
                        ctl_d.wdt_seen = 1'b0;
                        ctl_d.pend     = '0;
                        capture        = 1'b1;
                    end else begin
                        ctl_d.int_rst  = 1'b1;
                        restore        = 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (|hit) begin
                    ctl_d.state   = ST_WAIT;
                    ctl_d.pend    = hit;
                    ctl_d.tmr_ovr = 1'b1;
                    cnt_load      = 1'b1;
                end
            end
            ST_WAIT: begin
                cnt_dec    = 1'b1;
                ctl_d.pend = ctl_q.pend | hit;
                if (cnt_zero) begin
                    ctl_d.state   = ST_RUN;
                    ctl_d.irq_set = ctl_q.pend | hit;
                    ctl_d.pend    = '0;
                end
            end
            default: ctl_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_RUN;
            ctl_q.wdt_seen <= 1'b0;
            ctl_q.pend     <= '0;
            ctl_q.irq_set  <= '0;
            ctl_q.tmr_ovr  <= 1'b0;
            ctl_q.int_rst  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign core_run_o = (ctl_q.state == ST_RUN);
    assign xin_on_o   = (ctl_q.state != ST_STOP) && mode.xin;
    assign xcin_on_o  = (ctl_q.state != ST_STOP) && mode.xcin;
    assign sub_sel_o  = mode.sub_sel;
    assign tmr_ovr_o  = ctl_q.tmr_ovr;
    assign irq_set_o  = ctl_q.irq_set;
    assign int_rst_o  = ctl_q.int_rst;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
    parameter int NSRC = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stop_req_i,
    input logic            core_run_o,
    input logic            xin_on_o,
    input logic            xcin_on_o,
    input logic            sub_sel_o,
    input logic            tmr_ovr_o,
    input logic [NSRC-1:0] irq_set_o,
    input logic            int_rst_o
);
    // R2
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_run_o) |-> (!xin_on_o && !xcin_on_o));

    // R3
    int_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_o |-> (core_run_o && $past(stop_req_i) && xin_on_o && !xcin_on_o && !sub_sel_o));

    // R6
    tmr_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovr_o |-> (!core_run_o && (xin_on_o || xcin_on_o)));

    // R7
    main_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_run_o) && !sub_sel_o) |-> !$past(tmr_ovr_o));

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_set_o) |-> $rose(core_run_o));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run_o |=> $stable(sub_sel_o));
endmodule

bind stop_wake_ctrl swc_checker #(.NSRC(NSRC)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req_i (stop_req_i),
    .core_run_o (core_run_o),
    .xin_on_o   (xin_on_o),
    .xcin_on_o  (xcin_on_o),
    .sub_sel_o  (sub_sel_o),
    .tmr_ovr_o  (tmr_ovr_o),
    .irq_set_o  (irq_set_o),
    .int_rst_o  (int_rst_o)
);

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
    localparam int NS = 11;
    localparam int MAIN_WAIT = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, wdt_wr = 1'b0, cm_wr = 1'b0;
    logic cm_xin = 1'b0, cm_xcin = 1'b0, cm_sub = 1'b0, iflag = 1'b0;
    logic [NS-1:0] irq_en = '0, irq_flag = '0, irq_ev = '0;
    logic core_run, xin_on, xcin_on, sub_sel, tmr_ovr, int_rst;
    logic [NS-1:0] irq_set;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stop_wake_ctrl i_stop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req_i(stop_req), .wdt_wr_i(wdt_wr),
        .cm_wr_i(cm_wr), .cm_xin_i(cm_xin), .cm_xcin_i(cm_xcin), .cm_sub_sel_i(cm_sub),
        .iflag_i(iflag), .irq_en_i(irq_en), .irq_flag_i(irq_flag), .irq_ev_i(irq_ev),
        .core_run_o(core_run), .xin_on_o(xin_on), .xcin_on_o(xcin_on), .sub_sel_o(sub_sel),
        .tmr_ovr_o(tmr_ovr), .irq_set_o(irq_set), .int_rst_o(int_rst)
    );

    typedef struct packed {
        logic [NS-1:0] en;
        logic [NS-1:0] flg;
        logic          ifl;
        logic [NS-1:0] ev;
        logic          wake;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{11'h001, 11'h000, 1'b0, 11'h001, 1'b1},
        '{11'h001, 11'h001, 1'b0, 11'h001, 1'b0},
        '{11'h008, 11'h000, 1'b1, 11'h008, 1'b0},
        '{11'h100, 11'h000, 1'b0, 11'h100, 1'b1},
        '{11'h200, 11'h000, 1'b0, 11'h200, 1'b0},
        '{11'h050, 11'h000, 1'b0, 11'h040, 1'b1},
        '{11'h002, 11'h000, 1'b0, 11'h004, 1'b0},
        '{11'h400, 11'h000, 1'b0, 11'h400, 1'b0}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic set_mode(input logic x, input logic c, input logic s);
        cm_wr = 1'b1; cm_xin = x; cm_xcin = c; cm_sub = s;
        step();
        cm_wr = 1'b0;
    endtask

    task automatic wdt_write();
        wdt_wr = 1'b1;
        step();
        wdt_wr = 1'b0;
    endtask

    task automatic req_stop();
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
    endtask

    task automatic fire(input logic [NS-1:0] ev);
        irq_ev = ev;
        step();
        irq_ev = '0;
    endtask

    task automatic wait_run(output int n);
        n = 0;
        while (!core_run && n < 20000) begin
            step();
            n++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        step();
        do_reset();

        // R1: reset state
        check("R1 core_run", core_run, 1);
        check("R1 xin_on", xin_on, 1);
        check("R1 xcin_on", xcin_on, 0);
        check("R1 sub_sel", sub_sel, 0);
        check("R1 pulses", {tmr_ovr, int_rst, irq_set}, 0);

        // R5: arming table, sub clock selected for a one-cycle release
        foreach (VECS[i]) begin
            do_reset();
            set_mode(1'b1, 1'b1, 1'b1);
            irq_en = VECS[i].en; irq_flag = VECS[i].flg; iflag = VECS[i].ifl;
            wdt_write();
            req_stop();
            check("R2 stopped", {core_run, xin_on, xcin_on}, 0);
            fire(VECS[i].ev);
            if (VECS[i].wake) begin
                check("R6 osc restored", {xin_on, xcin_on, tmr_ovr}, 3'b111);
                wait_run(n);
                check("R8 sub release cycles", n, 1);
                check("R9 irq_set", irq_set, VECS[i].ev);
            end else begin
                check("R5 unarmed ignored", {xin_on, xcin_on, tmr_ovr}, 0);
                repeat (3) step();
                check("R5 still stopped", core_run, 0);
            end
        end
        irq_en = '0; irq_flag = '0; iflag = 1'b0;

        // R3: stop without watchdog write, mode back to default
        do_reset();
        set_mode(1'b1, 1'b1, 1'b1);
        req_stop();
        check("R3 int_rst pulse", int_rst, 1);
        check("R3 core keeps running", core_run, 1);
        check("R3 default mode", {xin_on, xcin_on, sub_sel}, 3'b100);
        step();
        check("R3 single pulse", int_rst, 0);

        // R4 and R2: same-cycle write and stop, flag consumed
        do_reset();
        set_mode(1'b1, 1'b0, 1'b1);
        irq_en = 11'h001;
        wdt_wr = 1'b1; stop_req = 1'b1;
        step();
        wdt_wr = 1'b0; stop_req = 1'b0;
        check("R4 stop entered", {core_run, int_rst}, 0);
        fire(11'h001);
        wait_run(n);
        check("R4 woke", core_run, 1);
        req_stop();
        check("R2 flag cleared by stop", {int_rst, core_run}, 2'b11);

        // R7, R9, R10, R12: main clock wait with extra event and stray requests
        do_reset();
        set_mode(1'b1, 1'b1, 1'b0);
        irq_en = 11'h003;
        wdt_write();
        req_stop();
        cm_wr = 1'b1; cm_xin = 1'b0; cm_xcin = 1'b0; cm_sub = 1'b1;
        step();
        cm_wr = 1'b0;
        check("R10 write ignored in stop", sub_sel, 0);
        fire(11'h001);
        check("R6 both osc restart", {xin_on, xcin_on}, 2'b11);
        n = 1;
        step();
        irq_ev = 11'h002; stop_req = 1'b1;
        step();
        irq_ev = '0; stop_req = 1'b0;
        n = n + 1;
        begin
            int m;
            wait_run(m);
            n = n + m;
        end
        check("R7 main wait length", n, MAIN_WAIT);
        check("R12 stop ignored in wait", core_run, 1);
        check("R9 both sources set", irq_set, 11'h003);
        check("R10 mode held", {xin_on, xcin_on, sub_sel}, 3'b110);
        step();
        check("R9 one-cycle pulse", irq_set, 0);

        // R11: reset during stabilization aborts it
        wdt_write();
        req_stop();
        fire(11'h001);
        repeat (100) step();
        check("R11 in wait", core_run, 0);
        do_reset();
        check("R11 default state", {core_run, xin_on, xcin_on, sub_sel, tmr_ovr}, 5'b11000);
        req_stop();
        check("R11 flag cleared", int_rst, 1);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule